// File: doc/BRIEF.md
# YCbCr Superframe Line Packer

This block turns one video line into a double-length line on a byte-wide bus. The first half of each output line carries the luma of every pixel, interleaved with chroma. Each chroma byte is the rounded mean of one pixel pair. The second half carries the raw sensor value of every pixel on the same line, zero-extended to 16 bits and sent as two bytes, low byte first. A line sync marks exactly the valid bytes. A frame sync brackets each group of lines, with a front and back porch around the line syncs.

The caller owns the line storage. While a line is being sent, the packer drives a pixel index, and the caller returns that pixel's Y, Cb, Cr and raw value combinationally in the same cycle. The caller raises `line_rdy` when a complete line can be read, and must hold its contents until `line_taken` pulses. The packer waits in blanking for a late line, so no byte is skipped. A frame starts only after a `frame_start` strobe. A strobe that arrives while a frame is running is held and starts the next frame.

Top module: `lp_top`

## Requirements
- R1: Each line puts exactly 4*N_PIX bytes on the bus (1280 for the default 320 pixels) in consecutive clocks. `vid_lsync` is high in exactly those clocks, and `vid_data` is all zero whenever `vid_lsync` is low.
- R2: Output bytes 0 to 2*N_PIX-1 of a line follow the pattern Y(2k), Cb(k), Y(2k+1), Cr(k) for k = 0, 1, 2, and so on, with pixels counted from 0.
- R3: Cb(k) is (cb(2k)+cb(2k+1)+1)>>1 on 8-bit values. Cr(k) is formed the same way from the cr values. This rounds half up and cannot overflow.
- R4: Output bytes 2*N_PIX to 4*N_PIX-1 carry the raw value of pixel j at positions 2*N_PIX+2j and 2*N_PIX+2j+1. The first byte is raw bits 7:0. The second byte is {2'b00, raw bits 13:8}.
- R5: Each byte is driven on `vid_data[13:6]`, with the byte's MSB on bit 13. Bits 5:0 are always zero.
- R6: `vid_lsync` is high only while `vid_fsync` is high. `vid_fsync` rises at least VFP_LEN (at least 1) clocks before the first line sync of a frame rises. It falls exactly VBP_LEN (at least 1) clocks after the last line sync of the frame falls.
- R7: Each frame contains exactly N_LINES lines (default 240).
- R8: A line starts only when `line_rdy` is high and at least HB_MIN clocks of blanking have passed. If `line_rdy` comes late, the blanking is extended, nothing is driven on the bus, and every byte of the late line is still sent.
- R9: `line_taken` is a single-clock pulse that coincides with the last byte of each line.
- R10: A frame starts only after a `frame_start` strobe and at least VB_MIN idle clocks. A strobe seen during a frame is remembered. Without a strobe, `vid_fsync` stays low even while `line_rdy` is high.
- R11: During reset, `vid_lsync`, `vid_fsync`, `line_taken` and `vid_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-clock strobe that requests a new frame |
| line_rdy | input | 1 | Caller has a complete line readable at `rd_idx` |
| y_in | input | 8 | Luma of pixel `rd_idx` |
| cb_in | input | 8 | Blue-difference chroma of pixel `rd_idx` |
| cr_in | input | 8 | Red-difference chroma of pixel `rd_idx` |
| raw_in | input | RAW_W (14) | Raw value of pixel `rd_idx`, already one frame old |
| rd_idx | output | clog2(N_PIX) (9) | Pixel index read from the caller's line storage |
| line_taken | output | 1 | Pulse with the last byte of a line; caller may replace the line |
| vid_data | output | BUS_W (14) | Output bus, byte on bits 13:6 |
| vid_lsync | output | 1 | Line sync, high for valid bytes |
| vid_fsync | output | 1 | Frame sync |

## Verification
The bench feeds four kinds of line content in rotation. The first has hashed values, which expose a wrong interleave order or a pixel-pair offset. The second is all-ones chroma with raw values of 0x3FFF, which shows any sum overflow in the mean and any leak into bits 15:14 of the raw value. The third has chroma alternating between 0 and 1 within each pair, so a truncating mean is caught against the half-up rule. The fourth has small raw values, where a swapped byte order shows at once. In one line the ready input is held back for a long time, and in another gap no frame strobe is given, so the bench can tell stalling from dropping and waiting from starting on its own.

// File: rtl/lp_pkg.sv
package lp_pkg;

   typedef logic [7:0] byte_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_VFP  = 3'd1,
      ST_HBL  = 3'd2,
      ST_ACT  = 3'd3,
      ST_VBP  = 3'd4
   } lp_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lp_avg.sv
// Rounded mean of two unsigned values, half rounds up, one extra sum bit.
module lp_avg #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] m
);
   logic [W:0] sum;

   assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
   assign m   = sum[W:1];
endmodule

// File: rtl/lp_seq.sv
// Frame / line sequencer: porches, blanking, byte position, line count.
module lp_seq
   import lp_pkg::*;
#(
   parameter int N_PIX   = 320,
   parameter int N_LINES = 240,
   parameter int HB_MIN  = 16,
   parameter int VFP_LEN = 4,
   parameter int VBP_LEN = 4,
   parameter int VB_MIN  = 32,
   parameter int POS_W   = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             line_rdy,
   output logic             act,
   output logic             in_frame,
   output logic             last_byte,
   output logic [POS_W-1:0] pos
);
   localparam int LINE_BYTES = 4 * N_PIX;
   localparam int CNT_MAX    = imax(imax(HB_MIN, VB_MIN), imax(VFP_LEN, VBP_LEN));
   localparam int CNT_W      = $clog2(CNT_MAX + 1);
   localparam int LN_W       = $clog2(N_LINES + 1);

   localparam logic [CNT_W-1:0] C_VB  = CNT_W'(VB_MIN - 1);
   localparam logic [CNT_W-1:0] C_VFP = CNT_W'(VFP_LEN - 1);
   localparam logic [CNT_W-1:0] C_HB  = CNT_W'(HB_MIN - 1);
   localparam logic [CNT_W-1:0] C_VBP = CNT_W'(VBP_LEN - 1);
   localparam logic [POS_W-1:0] C_LASTPOS = POS_W'(LINE_BYTES - 1);
   localparam logic [LN_W-1:0]  C_LASTLN  = LN_W'(N_LINES - 1);

   lp_state_e        st;
   logic [CNT_W-1:0] cnt;
   logic [LN_W-1:0]  line_no;
   logic             pend;
   logic             blank_done;
   logic             go_frame;

   always_comb begin
      unique case (st)
         ST_IDLE: blank_done = (cnt == C_VB);
         ST_VFP:  blank_done = (cnt == C_VFP);
         ST_HBL:  blank_done = (cnt == C_HB);
         ST_VBP:  blank_done = (cnt == C_VBP);
         default: blank_done = 1'b0;
      endcase
   end

   assign go_frame  = (st == ST_IDLE) && blank_done && (pend || frame_start);
   assign act       = (st == ST_ACT);
   assign in_frame  = (st != ST_IDLE);
   assign last_byte = act && (pos == C_LASTPOS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         pos     <= '0;
         line_no <= '0;
         pend    <= 1'b0;
      end else begin
         pend <= go_frame ? 1'b0 : (pend | frame_start);
         unique case (st)
            ST_IDLE: begin
               if (go_frame) begin
                  st  <= ST_VFP;
                  cnt <= '0;
               end else if (!blank_done) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_VFP: begin
               if (blank_done) begin
                  st  <= ST_HBL;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HBL: begin
               if (blank_done && line_rdy) begin
                  st  <= ST_ACT;
                  pos <= '0;
               end else if (!blank_done) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ACT: begin
               if (last_byte) begin
                  pos <= '0;
                  cnt <= '0;
                  if (line_no == C_LASTLN) begin
                     line_no <= '0;
                     st      <= ST_VBP;
                  end else begin
                     line_no <= line_no + 1'b1;
                     st      <= ST_HBL;
                  end
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            ST_VBP: begin
               if (blank_done) begin
                  st  <= ST_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lp_pack.sv
// Byte selection: pixel-pair chroma mean, then raw value split low/high.
module lp_pack
   import lp_pkg::*;
#(
   parameter int N_PIX = 320,
   parameter int RAW_W = 14,
   parameter int POS_W = 11,
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic [POS_W-1:0] pos,
   input  byte_t            y_in,
   input  byte_t            cb_in,
   input  byte_t            cr_in,
   input  logic [RAW_W-1:0] raw_in,
   output logic [IDX_W-1:0] rd_idx,
   output byte_t            out_byte
);
   localparam int HALF = 2 * N_PIX;
   localparam logic [POS_W-1:0] C_HALF = POS_W'(HALF);

   logic             in_raw;
   logic [POS_W-1:0] rel;
   logic [1:0]       sub;
   logic [15:0]      raw_ext;
   byte_t            cb_hold, cr_hold, y_hold, cr_mean_q;
   byte_t            cb_mean, cr_mean;

   assign in_raw  = (pos >= C_HALF);
   assign rel     = in_raw ? (pos - C_HALF) : pos;
   assign sub     = pos[1:0];
   assign raw_ext = 16'(raw_in);

   // chroma half: even pixel on sub 0, odd pixel from sub 1 on
   assign rd_idx = in_raw ? IDX_W'(rel >> 1)
                          : (IDX_W'(pos >> 1) | IDX_W'(pos[0]));

   lp_avg #(.W(8)) u_cb_mean (.a(cb_hold), .b(cb_in), .m(cb_mean));
   lp_avg #(.W(8)) u_cr_mean (.a(cr_hold), .b(cr_in), .m(cr_mean));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cb_hold   <= '0;
         cr_hold   <= '0;
         y_hold    <= '0;
         cr_mean_q <= '0;
      end else if (act && !in_raw) begin
         if (sub == 2'd0) begin
            cb_hold <= cb_in;
            cr_hold <= cr_in;
         end else if (sub == 2'd1) begin
            y_hold    <= y_in;
            cr_mean_q <= cr_mean;
         end
      end
   end

   always_comb begin
      if (in_raw) begin
         out_byte = rel[0] ? raw_ext[15:8] : raw_ext[7:0];
      end else begin
         unique case (sub)
            2'd0:    out_byte = y_in;
            2'd1:    out_byte = cb_mean;
            2'd2:    out_byte = y_hold;
            default: out_byte = cr_mean_q;
         endcase
      end
   end
endmodule

// File: rtl/lp_top.sv
module lp_top
   import lp_pkg::*;
#(
   parameter int N_PIX    = 320,
   parameter int N_LINES  = 240,
   parameter int RAW_W    = 14,
   parameter int BUS_W    = 14,
   parameter int BYTE_LSB = 6,
   parameter int HB_MIN   = 16,
   parameter int VFP_LEN  = 4,
   parameter int VBP_LEN  = 4,
   parameter int VB_MIN   = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_start,
   input  logic                     line_rdy,
   input  logic [7:0]               y_in,
   input  logic [7:0]               cb_in,
   input  logic [7:0]               cr_in,
   input  logic [RAW_W-1:0]         raw_in,
   output logic [$clog2(N_PIX)-1:0] rd_idx,
   output logic                     line_taken,
   output logic [BUS_W-1:0]         vid_data,
   output logic                     vid_lsync,
   output logic                     vid_fsync
);
   localparam int LINE_BYTES = 4 * N_PIX;
   localparam int POS_W      = $clog2(LINE_BYTES);
   localparam int IDX_W      = $clog2(N_PIX);

   if (N_PIX < 2 || (N_PIX % 2) != 0) begin : g_bad_pix
      $error("lp_top: N_PIX must be even and at least 2");
   end
   if (N_LINES < 1) begin : g_bad_lines
      $error("lp_top: N_LINES must be at least 1");
   end
   if (RAW_W < 9 || RAW_W > 16) begin : g_bad_raw
      $error("lp_top: RAW_W must lie in 9..16");
   end
   if (BUS_W < BYTE_LSB + 8) begin : g_bad_bus
      $error("lp_top: byte does not fit on the bus");
   end
   if (HB_MIN < 2 || VFP_LEN < 1 || VBP_LEN < 1 || VB_MIN < 1) begin : g_bad_blank
      $error("lp_top: blanking minimums too small");
   end

   logic             act, in_frame, last_byte;
   logic [POS_W-1:0] pos;
   byte_t            pk_byte;
   logic [BUS_W-1:0] bus_nxt;

   lp_seq #(
      .N_PIX(N_PIX), .N_LINES(N_LINES), .HB_MIN(HB_MIN), .VFP_LEN(VFP_LEN),
      .VBP_LEN(VBP_LEN), .VB_MIN(VB_MIN), .POS_W(POS_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_rdy(line_rdy),
      .act(act), .in_frame(in_frame), .last_byte(last_byte), .pos(pos)
   );

   lp_pack #(
      .N_PIX(N_PIX), .RAW_W(RAW_W), .POS_W(POS_W), .IDX_W(IDX_W)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .act(act), .pos(pos),
      .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in), .raw_in(raw_in),
      .rd_idx(rd_idx), .out_byte(pk_byte)
   );

   assign bus_nxt = act ? (BUS_W'(pk_byte) << BYTE_LSB) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vid_data   <= '0;
         vid_lsync  <= 1'b0;
         vid_fsync  <= 1'b0;
         line_taken <= 1'b0;
      end else begin
         vid_data   <= bus_nxt;
         vid_lsync  <= act;
         vid_fsync  <= in_frame;
         line_taken <= last_byte;
      end
   end
endmodule

// File: rtl/lp_chk.sv
module lp_chk #(
   parameter int LINE_BYTES = 1280,
   parameter int BUS_W      = 14,
   parameter int BYTE_LSB   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_rdy,
   input logic             line_taken,
   input logic [BUS_W-1:0] vid_data,
   input logic             vid_lsync,
   input logic             vid_fsync
);
   localparam int RUN_W = $clog2(LINE_BYTES + 1);
   localparam logic [BUS_W-1:0] LOW_MASK = BUS_W'((1 << BYTE_LSB) - 1);
   localparam logic [RUN_W-1:0] C_LB = RUN_W'(LINE_BYTES);

   logic [RUN_W-1:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n) run <= '0;
      else        run <= vid_lsync ? run + 1'b1 : '0;
   end

   p_lsync_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vid_lsync) |-> run == C_LB);
   p_lsync_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      vid_lsync |-> run < C_LB);
   p_idle_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_lsync |-> vid_data == '0);
   p_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_data & LOW_MASK) == '0);
   p_ls_in_fs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vid_lsync |-> vid_fsync);
   p_fs_front_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vid_lsync) |-> $past(vid_fsync));
   p_fs_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vid_fsync) |-> !$past(vid_lsync));
   p_wait_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vid_lsync) |-> $past(line_rdy, 2));
   p_taken_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_taken |-> vid_lsync && run == C_LB - 1'b1);
   p_taken_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_taken |=> !line_taken && !vid_lsync);
endmodule

bind lp_top lp_chk #(
   .LINE_BYTES(4 * N_PIX), .BUS_W(BUS_W), .BYTE_LSB(BYTE_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_rdy(line_rdy), .line_taken(line_taken),
   .vid_data(vid_data), .vid_lsync(vid_lsync), .vid_fsync(vid_fsync)
);

// File: tb/sim_lp_top.sv
`timescale 1ns/1ps
module sim_lp_top;
   localparam int CLK_PERIOD = 10;
   localparam int N_PIX   = 320;
   localparam int N_LINES = 3;
   localparam int HB      = 4;
   localparam int VFP     = 3;
   localparam int VBP     = 2;
   localparam int VB      = 5;
   localparam int LB      = 4 * N_PIX;
   localparam int HALF    = 2 * N_PIX;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        line_rdy = 1'b0;
   logic [7:0]  y_in, cb_in, cr_in;
   logic [13:0] raw_in;
   logic [8:0]  rd_idx;
   logic        line_taken;
   logic [13:0] vid_data;
   logic        vid_lsync, vid_fsync;

   int errors = 0;
   int checks = 0;
   int gl = 0;
   bit done = 1'b0;
   logic [13:0] expq[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   lp_top #(
      .N_PIX(N_PIX), .N_LINES(N_LINES), .HB_MIN(HB), .VFP_LEN(VFP),
      .VBP_LEN(VBP), .VB_MIN(VB)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_rdy(line_rdy),
      .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in), .raw_in(raw_in),
      .rd_idx(rd_idx), .line_taken(line_taken), .vid_data(vid_data),
      .vid_lsync(vid_lsync), .vid_fsync(vid_fsync)
   );

   // caller line content, four patterns rotating by line number
   function automatic int px_y(int ln, int p);
      case (ln % 4)
         0: return (ln * 37 + p * 5) & 255;
         1: return 255 - (p & 255);
         2: return p & 255;
         default: return 0;
      endcase
   endfunction
   function automatic int px_cb(int ln, int p);
      case (ln % 4)
         0: return (p * 11 + ln) & 255;
         1: return 255;
         2: return p % 2;
         default: return 0;
      endcase
   endfunction
   function automatic int px_cr(int ln, int p);
      case (ln % 4)
         0: return (200 + p * 7 + ln * 3) & 255;
         1: return 255;
         2: return (p + 1) % 2;
         default: return 0;
      endcase
   endfunction
   function automatic int px_raw(int ln, int p);
      case (ln % 4)
         0: return (ln * 1021 + p * 193) & 16383;
         1: return 16383;
         2: return (p * 65) & 16383;
         default: return p * 3;
      endcase
   endfunction

   assign y_in   = 8'(px_y(gl, int'(rd_idx)));
   assign cb_in  = 8'(px_cb(gl, int'(rd_idx)));
   assign cr_in  = 8'(px_cr(gl, int'(rd_idx)));
   assign raw_in = 14'(px_raw(gl, int'(rd_idx)));

   // expected byte from R2, R3, R4
   function automatic int exp_byte(int ln, int p);
      int g, s, r, v;
      if (p < HALF) begin
         g = p / 4;
         s = p % 4;
         case (s)
            0: return px_y(ln, 2 * g);
            1: return (px_cb(ln, 2 * g) + px_cb(ln, 2 * g + 1) + 1) / 2;
            2: return px_y(ln, 2 * g + 1);
            default: return (px_cr(ln, 2 * g) + px_cr(ln, 2 * g + 1) + 1) / 2;
         endcase
      end
      r = p - HALF;
      v = px_raw(ln, r / 2);
      return (r % 2 == 0) ? (v & 255) : (v >> 8);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic pulse_fs();
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic push_line();
      for (int p = 0; p < LB; p++) expq.push_back(14'(exp_byte(gl, p) << 6));
   endtask

   task automatic wait_taken();
      do @(negedge clk); while (!line_taken);
      line_rdy = 1'b0;
      gl++;
   endtask

   task automatic run_line(input int pre_delay, input bit mid_strobe);
      int hi = 0;
      for (int i = 0; i < pre_delay; i++) begin
         @(negedge clk);
         if (vid_lsync) hi++;
      end
      if (pre_delay > 0) chk(hi == 0, "R8 bus quiet while line late", hi, 0);
      push_line();
      line_rdy = 1'b1;
      if (mid_strobe) begin
         repeat (100) @(negedge clk);
         pulse_fs();
      end
      wait_taken();
   endtask

   // monitor / scoreboard
   bit prev_ls = 1'b0, prev_fs = 1'b0;
   int run = 0, since_fs = 0, since_ls = 0, lines = 0, frames = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         since_fs++;
         since_ls++;
         if (vid_fsync && !prev_fs) since_fs = 0;
         if (vid_lsync && !prev_ls) begin
            chk(prev_fs, "R6 fsync high before lsync rise", int'(prev_fs), 1);
            chk(since_fs >= VFP, "R6 front porch", since_fs, VFP);
            lines++;
            run = 0;
         end
         if (vid_lsync) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R8 byte with nothing expected", int'(vid_data), -1);
            end else begin
               logic [13:0] e;
               e = expq.pop_front();
               if (run < HALF)
                  chk(vid_data == e, (run % 2) ? "R3/R5 chroma mean" : "R2/R5 luma order",
                      int'(vid_data), int'(e));
               else
                  chk(vid_data == e, "R4/R5 raw bytes", int'(vid_data), int'(e));
            end
            run++;
         end else begin
            chk(vid_data == 14'd0, "R1 bus zero in blanking", int'(vid_data), 0);
         end
         if (!vid_lsync && prev_ls) begin
            chk(run == LB, "R1 line length", run, LB);
            since_ls = 0;
         end
         if (!vid_fsync && prev_fs) begin
            chk(!prev_ls, "R6 lsync low before fsync fall", int'(prev_ls), 0);
            chk(since_ls == VBP, "R6 back porch", since_ls, VBP);
            chk(lines == N_LINES, "R7 lines per frame", lines, N_LINES);
            frames++;
            lines = 0;
         end
         if (line_taken)
            chk(vid_lsync && run == LB, "R9 taken with last byte", run, LB);
         prev_ls = vid_lsync;
         prev_fs = vid_fsync;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(vid_lsync == 1'b0, "R11 reset lsync", int'(vid_lsync), 0);
      chk(vid_fsync == 1'b0, "R11 reset fsync", int'(vid_fsync), 0);
      chk(line_taken == 1'b0, "R11 reset taken", int'(line_taken), 0);
      chk(vid_data == 14'd0, "R11 reset data", int'(vid_data), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // frame 0: explicit strobe, late second line, strobe for frame 1 held
      pulse_fs();
      run_line(0, 1'b0);
      run_line(200, 1'b0);
      run_line(0, 1'b1);
      // frame 1: started from the remembered strobe
      run_line(0, 1'b0);
      run_line(0, 1'b0);
      run_line(0, 1'b1);
      // frame 2: no strobe for a following frame
      run_line(0, 1'b0);
      run_line(0, 1'b0);
      run_line(0, 1'b0);

      while (vid_fsync) @(negedge clk);
      begin
         int hi = 0;
         push_line();
         line_rdy = 1'b1;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (vid_fsync || vid_lsync) hi++;
         end
         chk(hi == 0, "R10 no frame without strobe", hi, 0);
      end
      pulse_fs();
      wait_taken();
      run_line(0, 1'b0);
      run_line(0, 1'b0);

      while (vid_fsync) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(expq.size() == 0, "R8 every queued byte sent", expq.size(), 0);
      chk(frames == 4, "R10 frames started", frames, 4);
      report();
   end
endmodule